// File: doc/BRIEF.md
# SDRAM Deep Power-Down Sequencer

This block sits on the controller side of a mobile SDRAM and walks the memory into its lowest-power state and back out again. The host raises a one-cycle enter request. The block holds that request until a status input reports that every bank is precharged and idle. It then issues the power-down command on the command pins with the clock enable dropped, and keeps the clock enable low for as long as the memory rests there.

An exit request releases the clock enable. The memory array loses its contents in this state, so the block does not go back to normal operation on exit. It raises an initialization request toward a separate start-up engine and stays busy until that engine reports completion. A parameter sets the minimum number of cycles the memory must stay powered down before an exit is accepted.

Top module: `sdram_dpd_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, cke is 1, the pins carry a no-operation command (cs_n=0, ras_n=1, cas_n=1, we_n=1), busy is 0 and init_req is 0.
- R2: An enter request is taken only when banks_idle is 1 at a clock edge. A request seen while banks_idle is 0 is remembered, and it takes effect at the first later edge where banks_idle is 1.
- R3: The power-down command lasts exactly one cycle: cke=0, cs_n=0, ras_n=1, cas_n=1, we_n=0. It starts in the cycle after the edge that accepts the enter request, and the powered-down state follows it directly.
- R4: cke stays 0 in every cycle the block spends in the powered-down state.
- R5: In every cycle other than the power-down command cycle, the pins carry the no-operation command.
- R6: An exit request given while the block is not in the powered-down state has no effect, and it is not remembered for a later stay in that state.
- R7: An exit request is honoured only at an edge where the block has spent at least MIN_DPD_CYCLES cycles powered down. An earlier exit request made during the stay is remembered until that point.
- R8: On exit, cke returns to 1 and init_req rises in the same cycle. init_req stays 1 until the block samples init_done at an edge after the exit cycle, and then returns to idle.
- R9: An enter request made while the block waits for initialization is held, and it starts a new entry once initialization is done and banks_idle is 1.
- R10: busy is 0 only in the idle state and 1 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enter_req | input | 1 | Host request to power down (pulse) |
| exit_req | input | 1 | Host request to wake up (pulse) |
| banks_idle | input | 1 | All banks precharged and idle |
| init_done | input | 1 | Initialization engine has finished |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| init_req | output | 1 | Asks for a full initialization sequence |
| busy | output | 1 | Block is not in its idle state |

## Verification
The assertions assume that every input is a known 0 or 1 after reset. They also assume that banks_idle honestly reflects the banks in the cycle it is sampled, because the entry check only looks at that input one edge back. init_done is taken to mean something only while initialization is requested. The stimulus changes inputs only on the falling edge and draws each one as a clean bit from a seeded generator. Directed phases deliberately hold banks_idle low, wake the block early and send stray exit or enter pulses, so that the holding and ignoring paths are reached.

// File: rtl/sdram_dpd_pkg.sv
package sdram_dpd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_READY = 3'd0,
    ST_ENTER      = 3'd1,
    ST_DPD        = 3'd2,
    ST_EXIT       = 3'd3,
    ST_WAIT_INIT  = 3'd4
  } dpd_state_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_pins_t;

  localparam sdram_pins_t PINS_NOP_ON  = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdram_pins_t PINS_NOP_OFF = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdram_pins_t PINS_PD_CMD  = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

  // Pin pattern presented while the sequencer sits in a given state.
  function automatic sdram_pins_t pins_for(dpd_state_e s);
    case (s)
      ST_ENTER: return PINS_PD_CMD;
      ST_DPD:   return PINS_NOP_OFF;
      default:  return PINS_NOP_ON;
    endcase
  endfunction

  // Saturating step of the dwell counter.
  function automatic int unsigned dwell_step(int unsigned cur, int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

endpackage

// File: rtl/dpd_dwell_cnt.sv
module dpd_dwell_cnt #(
  parameter int unsigned MIN_DPD_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic dwell_met
);
  import sdram_dpd_pkg::*;

  localparam int unsigned LIMIT = (MIN_DPD_CYCLES < 1) ? 1 : MIN_DPD_CYCLES;
  localparam int CNT_W = $clog2(LIMIT + 1) + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(1);
    end else if (run) begin
      cnt_q <= CNT_W'(dwell_step(int'(cnt_q), LIMIT));
    end
  end

  assign dwell_met = (cnt_q >= CNT_W'(LIMIT));
endmodule

// File: rtl/dpd_fsm.sv
module dpd_fsm (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enter_req,
  input  logic                      exit_req,
  input  logic                      banks_idle,
  input  logic                      init_done,
  input  logic                      dwell_met,
  output sdram_dpd_pkg::dpd_state_e state
);
  import sdram_dpd_pkg::*;

  dpd_state_e st_q, st_d;
  logic enter_pend_q, enter_pend_d;
  logic exit_pend_q, exit_pend_d;
  logic enter_any, exit_any;

  assign enter_any = enter_pend_q | enter_req;
  assign exit_any  = exit_pend_q | exit_req;

  always_comb begin
    st_d         = st_q;
    enter_pend_d = enter_any;
    exit_pend_d  = 1'b0;
    case (st_q)
      ST_IDLE_READY: begin
        if (enter_any && banks_idle) begin
          st_d         = ST_ENTER;
          enter_pend_d = 1'b0;
        end
      end
      ST_ENTER: st_d = ST_DPD;
      ST_DPD: begin
        if (exit_any && dwell_met) begin
          st_d = ST_EXIT;
        end else begin
          exit_pend_d = exit_any;
        end
      end
      ST_EXIT: st_d = ST_WAIT_INIT;
      ST_WAIT_INIT: begin
        if (init_done) st_d = ST_IDLE_READY;
      end
      default: st_d = ST_IDLE_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE_READY;
      enter_pend_q <= 1'b0;
      exit_pend_q  <= 1'b0;
    end else begin
      st_q         <= st_d;
      enter_pend_q <= enter_pend_d;
      exit_pend_q  <= exit_pend_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/dpd_pin_enc.sv
module dpd_pin_enc (
  input  sdram_dpd_pkg::dpd_state_e state,
  output logic                      cke,
  output logic                      cs_n,
  output logic                      ras_n,
  output logic                      cas_n,
  output logic                      we_n,
  output logic                      init_req,
  output logic                      busy
);
  import sdram_dpd_pkg::*;

  sdram_pins_t pins;

  always_comb pins = pins_for(state);

  assign cke      = pins.cke;
  assign cs_n     = pins.cs_n;
  assign ras_n    = pins.ras_n;
  assign cas_n    = pins.cas_n;
  assign we_n     = pins.we_n;
  assign init_req = (state == ST_EXIT) || (state == ST_WAIT_INIT);
  assign busy     = (state != ST_IDLE_READY);
endmodule

// File: rtl/sdram_dpd_seq.sv
module sdram_dpd_seq #(
  parameter int unsigned MIN_DPD_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic exit_req,
  input  logic banks_idle,
  input  logic init_done,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_req,
  output logic busy
);
  import sdram_dpd_pkg::*;

  dpd_state_e state;
  logic dwell_met;

  // Named internal events for the checker.
  logic entry_edge;
  logic exit_edge;
  logic dpd_active;

  assign entry_edge = (state == ST_ENTER);
  assign exit_edge  = (state == ST_EXIT);
  assign dpd_active = (state == ST_DPD);

  dpd_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_req  (enter_req),
    .exit_req   (exit_req),
    .banks_idle (banks_idle),
    .init_done  (init_done),
    .dwell_met  (dwell_met),
    .state      (state)
  );

  dpd_dwell_cnt #(.MIN_DPD_CYCLES(MIN_DPD_CYCLES)) u_dwell (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (entry_edge),
    .run       (dpd_active),
    .dwell_met (dwell_met)
  );

  dpd_pin_enc u_enc (
    .state    (state),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .init_req (init_req),
    .busy     (busy)
  );
endmodule

// File: rtl/sdram_dpd_seq_chk.sv
module sdram_dpd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic banks_idle,
  input logic init_done,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic init_req,
  input logic busy,
  input logic entry_edge,
  input logic exit_edge,
  input logic dpd_active
);

  // R2: the power-down command follows an edge that saw idle banks
  a_r2_entry_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    entry_edge |-> $past(banks_idle));

  // R3: command pins during the power-down command
  a_r3_entry_pins: assert property (@(posedge clk) disable iff (!rst_n)
    entry_edge |-> (!cke && !cs_n && ras_n && cas_n && !we_n));

  // R3: the powered-down state follows at once
  a_r3_then_dpd: assert property (@(posedge clk) disable iff (!rst_n)
    entry_edge |=> dpd_active);

  // R4: clock enable held low while powered down
  a_r4_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_active |-> !cke);

  // R5: no-operation on the pins outside the command cycle
  a_r5_nop_else: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_edge |-> (!cs_n && ras_n && cas_n && we_n));

  // R8: clock enable only rises when leaving the powered-down state
  a_r8_cke_rise_from_dpd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (exit_edge && $past(dpd_active)));

  // R8: init request persists until completion is seen
  a_r8_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && (exit_edge || !init_done)) |=> init_req);

  // R10: init request implies busy
  a_r10_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req || dpd_active || entry_edge) |-> busy);

endmodule

bind sdram_dpd_seq sdram_dpd_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .banks_idle (banks_idle),
  .init_done  (init_done),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .init_req   (init_req),
  .busy       (busy),
  .entry_edge (entry_edge),
  .exit_edge  (exit_edge),
  .dpd_active (dpd_active)
);

// File: tb/sdram_dpd_seq_tb.sv
module sdram_dpd_seq_tb;
  localparam int MIN_DWELL = 3;
  localparam int M_IDLE = 0, M_ENTER = 1, M_DPD = 2, M_EXIT = 3, M_WAIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_req = 1'b0, exit_req = 1'b0, banks_idle = 1'b1, init_done = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_req, busy;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_dpd_seq #(.MIN_DPD_CYCLES(MIN_DWELL)) u_dut (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
    .banks_idle(banks_idle), .init_done(init_done), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_req(init_req), .busy(busy)
  );

  // Bench model built from the requirements.
  int  m_st = M_IDLE;
  bit  m_ent = 0, m_ext = 0;
  int  m_cnt = 0;

  function automatic logic [4:0] exp_pins(int s);
    if (s == M_ENTER) return 5'b0_0110;
    if (s == M_DPD)   return 5'b0_0111;
    return 5'b1_0111;
  endfunction

  function automatic string req_of(int s);
    case (s)
      M_ENTER: return "R3";
      M_DPD:   return "R4";
      M_EXIT, M_WAIT: return "R8";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= M_IDLE; m_ent <= 0; m_ext <= 0; m_cnt <= 0;
    end else begin
      m_ext <= 0;
      m_ent <= m_ent | enter_req;
      case (m_st)
        M_IDLE: if ((m_ent | enter_req) && banks_idle) begin m_st <= M_ENTER; m_ent <= 0; end
        M_ENTER: begin m_st <= M_DPD; m_cnt <= 1; end
        M_DPD: begin
          if ((m_ext | exit_req) && m_cnt >= MIN_DWELL) m_st <= M_EXIT;
          else begin
            m_ext <= m_ext | exit_req;
            if (m_cnt < MIN_DWELL) m_cnt <= m_cnt + 1;
          end
        end
        M_EXIT: m_st <= M_WAIT;
        default: if (init_done) m_st <= M_IDLE;
      endcase
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      check(req_of(m_st), {3'b0, cke, cs_n, ras_n, cas_n, we_n}, {3'b0, exp_pins(m_st)});
      check("R8", {7'b0, init_req}, {7'b0, (m_st == M_EXIT || m_st == M_WAIT)});
      check("R10", {7'b0, busy}, {7'b0, (m_st != M_IDLE)});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_enter;
    enter_req = 1'b1; cyc(1); enter_req = 1'b0;
  endtask

  task automatic pulse_exit;
    exit_req = 1'b1; cyc(1); exit_req = 1'b0;
  endtask

  task automatic summary;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0dd5));
    cyc(3);
    // R1: reset values
    check("R1", {3'b0, cke, cs_n, ras_n, cas_n, we_n}, 8'h17);
    check("R1", {6'b0, busy, init_req}, 8'h00);
    rst_n = 1'b1;
    cyc(1);
    check("R1", {6'b0, busy, init_req}, 8'h00);

    // R6: stray exit while idle, then enter; stays powered down
    pulse_exit();
    cyc(2);
    check("R6", {7'b0, busy}, 8'h00);
    pulse_enter();               // ENTER visible now
    check("R3", {3'b0, cke, cs_n, ras_n, cas_n, we_n}, 8'h06);
    cyc(10);
    check("R6", {7'b0, cke}, 8'h00);

    // R7: early exit is remembered until dwell met (already met here), prompt exit
    pulse_exit();                // EXIT visible now
    check("R8", {6'b0, cke, init_req}, 8'h03);
    cyc(3);
    check("R8", {7'b0, init_req}, 8'h01);
    init_done = 1'b1; cyc(1); init_done = 1'b0;
    check("R8", {6'b0, busy, init_req}, 8'h00);

    // R2: enter while banks busy is held
    banks_idle = 1'b0;
    pulse_enter();
    cyc(5);
    check("R2", {7'b0, busy}, 8'h00);
    banks_idle = 1'b1;
    cyc(1);
    check("R2", {3'b0, cke, cs_n, ras_n, cas_n, we_n}, 8'h06);

    // R7: exit in first powered-down cycle waits for the dwell
    cyc(1);                      // first DPD cycle
    pulse_exit();                // edge with cnt=1: not honoured
    check("R7", {7'b0, cke}, 8'h00);
    cyc(1);
    check("R7", {7'b0, cke}, 8'h00);
    cyc(1);
    check("R7", {7'b0, cke}, 8'h01);

    // R9: enter during wait for init is held
    cyc(1);
    pulse_enter();
    cyc(3);
    check("R9", {7'b0, init_req}, 8'h01);
    init_done = 1'b1; cyc(1); init_done = 1'b0;
    cyc(1);
    check("R9", {3'b0, cke, cs_n, ras_n, cas_n, we_n}, 8'h06);
    cyc(MIN_DWELL + 1);
    pulse_exit();
    cyc(2);
    init_done = 1'b1; cyc(1); init_done = 1'b0;

    // Random phase, checked by the continuous model comparison.
    for (int i = 0; i < 4000; i++) begin
      enter_req  = ($urandom % 8) == 0;
      exit_req   = ($urandom % 6) == 0;
      banks_idle = ($urandom % 4) != 0;
      init_done  = ($urandom % 5) == 0;
      cyc(1);
    end
    enter_req = 1'b0; exit_req = 1'b0; init_done = 1'b0;
    cyc(2);
    summary();
  end
endmodule